// File: doc/BRIEF.md
# PMIC I2C Register Target

This block is the serial control port of a small power-management device. A bus controller addresses it over a two-wire I2C bus to set and inspect eight 8-bit configuration registers. The block runs entirely on a fast system clock of at least 16 times the SCL rate, so a 400 kHz bus is served from a 6.4 MHz or faster clock. Both bus lines are resynchronised and their edges are found digitally. SDA is driven as an open-drain enable: a high on `sda_oe_o` pulls the line low.

A write transaction carries the device address, a register pointer, and then any number of data bytes, with the pointer advancing after each byte. A read first sets the pointer with a write, then uses a repeated START and the read address, and the target returns bytes from the pointer onward. The low bit of the device address comes from a strap input, so two such devices can share one bus.

An enable input models "supply above lockout and at least one rail running". While it is low the port ignores the bus. When the device sits in wait mode with every rail off, the register bank returns to its defaults.

Top module: `pmic_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal {100100b, addr_sel_i}. It holds SDA low for the whole ninth clock pulse after each byte it accepts. A byte with any other address gets no acknowledge, and SDA stays released until the next START.
- R2: In a write (address bit 0 = 0), the first data byte loads the register pointer. Each later byte is stored in the register the pointer selects, and then the pointer increments.
- R3: In a read (address bit 0 = 1), the target sends the byte at the pointer MSB first and then increments the pointer. It keeps sending the next byte for as long as the controller acknowledges.
- R4: A START in any state abandons the current byte and restarts address reception. The register pointer is kept across a repeated START.
- R5: Reading an address of 08h or higher returns FFh. A write to such an address is acknowledged and then discarded, and no register changes.
- R6: When the controller does not acknowledge a read byte, the target stops sending and leaves SDA released until the next START or STOP.
- R7: While if_enable_i is low, the target never drives SDA and no register changes as a result of bus traffic.
- R8: While wait_mode_i is high and rail_on_i is low, every register holds its default, which is 11h times its index. If a rail is on in wait mode, the registers keep their contents.
- R9: Apart from reacting to START, STOP or loss of enable, the target changes its SDA drive only while the synchronised SCL is low. A STOP releases SDA.
- R10: After reset, regs_o holds the defaults, with register i in bits [8i+7:8i], and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | High pulls SDA low (acknowledge or a read 0 bit) |
| addr_sel_i | input | 1 | Strap giving address bit 0 |
| if_enable_i | input | 1 | Supply good and a rail running; low ignores the bus |
| wait_mode_i | input | 1 | Device is in wait mode |
| rail_on_i | input | 1 | At least one rail is on |
| regs_o | output | 64 | All register contents, register i in bits [8i+7:8i] |

## Verification
On every cycle the assertions check several properties. SDA stays released while disabled and after STOP or a master NACK. A START always restarts address reception. Drive changes fall in the SCL-low phase. Forced defaults hold, and writes to unmapped addresses leave the bank unchanged. Only the bench's bus scenarios can show the byte-level behaviour: address matching against the strap, pointer auto-increment across writes and reads, FFh from unmapped reads, and data surviving a repeated START. Those checks compare against a register model kept in the bench.

// File: rtl/pmic_i2c_pkg.sv
package pmic_i2c_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } bus_state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } rx_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int MSB = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_prev;
        logic                   sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[MSB];
        d.sda_prev = q.sda_pipe[MSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_pipe[MSB];
    assign sda_s     = q.sda_pipe[MSB];
    assign scl_rise  = scl_s & ~q.scl_prev;
    assign scl_fall  = ~scl_s & q.scl_prev;
    assign start_det = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import pmic_i2c_pkg::*;
#(
    parameter int         DW      = 8,
    parameter logic [5:0] ADDR_HI = 6'b100100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          if_enable,
    input  logic          addr_sel,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [DW-1:0] rd_data,
    output logic [DW-1:0] rd_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sda_oe
);
    localparam int CW = $clog2(DW) + 1;

    typedef struct packed {
        bus_state_e    st;
        rx_kind_e      kind;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic [DW-1:0] ptr;
        logic          is_read;
        logic          mack;
        logic          wr_en;
        logic [DW-1:0] wr_addr;
        logic [DW-1:0] wr_data;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (!if_enable) begin
            d.st = ST_IDLE;
        end else if (start_det) begin
            d.st   = ST_RX;
            d.kind = K_ADDR;
            d.cnt  = '0;
        end else if (stop_det) begin
            d.st = ST_IDLE;
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[DW-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CW'(DW)) begin
                        unique case (q.kind)
                            K_ADDR: begin
                                if (q.sh[DW-1:1] == {ADDR_HI, addr_sel}) begin
                                    d.is_read = q.sh[0];
                                    d.kind    = q.sh[0] ? K_ADDR : K_PTR;
                                    d.st      = ST_ACK;
                                end else begin
                                    d.st = ST_IGNORE;
                                end
                            end
                            K_PTR: begin
                                d.ptr  = q.sh;
                                d.kind = K_DATA;
                                d.st   = ST_ACK;
                            end
                            default: begin
                                d.wr_en   = 1'b1;
                                d.wr_addr = q.ptr;
                                d.wr_data = q.sh;
                                d.ptr     = q.ptr + 1'b1;
                                d.st      = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.is_read) begin
                            d.st  = ST_TX;
                            d.sh  = rd_data;
                            d.ptr = q.ptr + 1'b1;
                        end else begin
                            d.st = ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        d.sh  = {q.sh[DW-2:0], 1'b0};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CW'(DW - 1)) d.st = ST_MACK;
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st  = ST_TX;
                            d.sh  = rd_data;
                            d.ptr = q.ptr + 1'b1;
                            d.cnt = '0;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.kind    <= K_ADDR;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.ptr;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign sda_oe  = (q.st == ST_ACK) | ((q.st == ST_TX) & ~q.sh[DW-1]);

    // Disabled port leaves the line alone (R7)
    assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !if_enable |=> !sda_oe);

    // START always re-enters address reception (R4)
    assert_start_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (if_enable && start_det) |=> (q.st == ST_RX && q.kind == K_ADDR && q.cnt == '0));

    // STOP releases SDA (R9)
    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (if_enable && stop_det && !start_det) |=> !sda_oe);

    // Drive changes only during SCL low, outside bus conditions (R9)
    assert_drive_in_low_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && $past(if_enable) && !$past(start_det) && !$past(stop_det))
        |-> !scl_s);

    // Master NACK ends the read with SDA released (R6)
    assert_nack_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (if_enable && !start_det && !stop_det && q.st == ST_MACK && scl_fall && !q.mack)
        |=> (!sda_oe && q.st == ST_IGNORE));
endmodule

// File: rtl/pm_regbank.sv
module pm_regbank #(
    parameter int                    NREG     = 8,
    parameter int                    DW       = 8,
    parameter int                    AW       = 8,
    parameter logic [NREG*DW-1:0]    DEFAULTS = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               force_def,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] regs_o
);
    localparam logic [DW-1:0] UNMAPPED = '1;

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (force_def)
                regs_d[i] = DEFAULTS[i*DW +: DW];
            else if (wr_en && wr_addr == AW'(i))
                regs_d[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= DEFAULTS[i*DW +: DW];
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rd_data = UNMAPPED;
        for (int i = 0; i < NREG; i++)
            if (rd_addr == AW'(i)) rd_data = regs_q[i];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_o[g*DW +: DW] = regs_q[g];
    end

    // Wait mode with all rails off pins the bank to defaults (R8)
    assert_defaults_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        force_def |=> (regs_o == DEFAULTS));

    // Unmapped writes are discarded (R5)
    assert_unmapped_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= AW'(NREG) && !force_def) |=> $stable(regs_o));

    // Without a write or a forced reset the contents are kept (R8)
    assert_contents_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !force_def) |=> $stable(regs_o));
endmodule

// File: rtl/pmic_i2c_target.sv
module pmic_i2c_target #(
    parameter int                 NREG         = 8,
    parameter int                 DW           = 8,
    parameter int                 SYNC_STAGES  = 2,
    parameter logic [5:0]         ADDR_HI      = 6'b100100,
    parameter logic [NREG*DW-1:0] REG_DEFAULTS = 64'h7766554433221100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic               addr_sel_i,
    input  logic               if_enable_i,
    input  logic               wait_mode_i,
    input  logic               rail_on_i,
    output logic [NREG*DW-1:0] regs_o
);
    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [DW-1:0] rd_addr, rd_data, wr_addr, wr_data;
    logic          wr_en;
    logic          force_def;

    assign force_def = wait_mode_i & ~rail_on_i;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_fsm #(.DW(DW), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .if_enable (if_enable_i),
        .addr_sel  (addr_sel_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe_o)
    );

    pm_regbank #(.NREG(NREG), .DW(DW), .AW(DW), .DEFAULTS(REG_DEFAULTS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_def (force_def),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .regs_o    (regs_o)
    );
endmodule

// File: tb/sim_pmic_i2c_target.sv
module sim_pmic_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic        if_enable = 1'b1;
    logic        wait_mode = 1'b0;
    logic        rail_on = 1'b1;
    logic        sda_oe;
    logic [63:0] regs;
    logic        sda_line;

    assign sda_line = sda_m & ~sda_oe;

    pmic_i2c_target u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .addr_sel_i  (addr_sel),
        .if_enable_i (if_enable),
        .wait_mode_i (wait_mode),
        .rail_on_i   (rail_on),
        .regs_o      (regs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0;
    int          fails = 0;
    int          drive_viol = 0;
    bit          done = 1'b0;
    logic [7:0]  model [8];
    logic [7:0]  wbuf [4];
    logic [7:0]  rbuf [4];
    bit          acks [6];

    function automatic logic [7:0] def_val(input int i);
        return 8'(17 * i);
    endfunction

    function automatic logic [7:0] exp_read(input int p);
        return (p < 8) ? model[p] : 8'hFF;
    endfunction

    function automatic logic [63:0] model_flat();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R9 monitor: drive may change only while SCL is low
    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n && if_enable && oe_prev != sda_oe && scl) drive_viol++;
        oe_prev <= sda_oe;
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_write(input logic b);
        sda_m = b; qwait();
        scl = 1'b1; qwait(); qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic bit_read(output logic b);
        sda_m = 1'b1; qwait();
        scl = 1'b1; qwait();
        b = sda_line; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic write_byte(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_write(v[i]);
        bit_read(b);
        ack = !b;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_read(b);
            v[i] = b;
        end
        bit_write(!mack);
    endtask

    // Write: address, pointer, n data bytes from wbuf; acks[0..n+1]
    task automatic do_write(input logic [6:0] dev, input logic [7:0] ptr, input int n);
        bit a;
        bus_start();
        write_byte({dev, 1'b0}, a); acks[0] = a;
        write_byte(ptr, a);         acks[1] = a;
        for (int i = 0; i < n; i++) begin
            write_byte(wbuf[i], a); acks[2+i] = a;
        end
        bus_stop();
    endtask

    // Pointer write, repeated START, read n bytes into rbuf
    task automatic do_read(input logic [6:0] dev, input logic [7:0] ptr, input int n);
        bit a;
        logic [7:0] v;
        bus_start();
        write_byte({dev, 1'b0}, a); acks[0] = a;
        write_byte(ptr, a);         acks[1] = a;
        bus_start();
        write_byte({dev, 1'b1}, a); acks[2] = a;
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, v);
            rbuf[i] = v;
        end
        bus_stop();
    endtask

    task automatic verify_read(input int ptr, input int n, input string req);
        for (int i = 0; i < n; i++)
            check(rbuf[i] === exp_read(ptr + i), req, 64'(rbuf[i]), 64'(exp_read(ptr + i)));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [6:0]  dev0;
        logic [6:0]  dev1;
        logic        b;
        int unsigned seed;
        dev0 = 7'b1001000;
        dev1 = 7'b1001001;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 8; i++) model[i] = def_val(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 reset state
        check(regs === model_flat(), "R10 defaults", regs, model_flat());
        check(sda_oe === 1'b0, "R10 sda released", 64'(sda_oe), 64'd0);

        // R1 / R2: directed write from pointer 2
        wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
        do_write(dev0, 8'h02, 2);
        model[2] = 8'hA5; model[3] = 8'h5A;
        check(acks[0] && acks[1] && acks[2] && acks[3], "R1 ack every byte",
              {60'd0, acks[3], acks[2], acks[1], acks[0]}, 64'hF);
        check(regs === model_flat(), "R2 write auto-increment", regs, model_flat());
        check(sda_oe === 1'b0, "R9 released after STOP", 64'(sda_oe), 64'd0);

        // R3 / R4: read back through repeated START
        do_read(dev0, 8'h01, 4);
        check(acks[2], "R4 read address acked after repeated START", 64'(acks[2]), 64'd1);
        verify_read(1, 4, "R3 sequential read");

        // R1: strap selects address bit 0
        addr_sel = 1'b1;
        wbuf[0] = 8'h3C;
        do_write(dev0, 8'h00, 1);
        check(!acks[0], "R1 mismatched address not acked", 64'(acks[0]), 64'd0);
        check(regs === model_flat(), "R1 mismatched write ignored", regs, model_flat());
        do_write(dev1, 8'h00, 1);
        model[0] = 8'h3C;
        check(acks[0], "R1 strap address acked", 64'(acks[0]), 64'd1);
        check(regs === model_flat(), "R1 strap address write", regs, model_flat());

        // R5: write past the map, read FFh beyond it
        wbuf[0] = 8'hC3; wbuf[1] = 8'h11; wbuf[2] = 8'h22;
        do_write(dev1, 8'h07, 3);
        model[7] = 8'hC3;
        check(acks[3] && acks[4], "R5 unmapped write acked",
              {62'd0, acks[4], acks[3]}, 64'h3);
        check(regs === model_flat(), "R5 unmapped write discarded", regs, model_flat());
        do_read(dev1, 8'h06, 4);
        verify_read(6, 4, "R5 unmapped read FFh");

        // R6: after master NACK the target leaves SDA high
        bus_start();
        write_byte({dev1, 1'b0}, acks[0]);
        write_byte(8'h00, acks[1]);
        bus_start();
        write_byte({dev1, 1'b1}, acks[2]);
        read_byte(1'b0, rbuf[0]);
        bit_read(b);
        check(b === 1'b1, "R6 SDA released after NACK", 64'(b), 64'd1);
        bus_stop();
        check(rbuf[0] === model[0], "R3 single byte read", 64'(rbuf[0]), 64'(model[0]));

        // R7: disabled interface ignores the bus
        if_enable = 1'b0;
        wbuf[0] = 8'h99;
        do_write(dev1, 8'h04, 1);
        check(!acks[0] && !acks[1] && !acks[2], "R7 no ack while disabled",
              {61'd0, acks[2], acks[1], acks[0]}, 64'd0);
        check(regs === model_flat(), "R7 registers untouched", regs, model_flat());
        if_enable = 1'b1;
        repeat (4) @(negedge clk);

        // R8: wait mode with a rail on keeps data; all rails off restores defaults
        wait_mode = 1'b1;
        repeat (3) @(negedge clk);
        check(regs === model_flat(), "R8 contents kept with rail on", regs, model_flat());
        rail_on = 1'b0;
        if_enable = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 8; i++) model[i] = def_val(i);
        check(regs === model_flat(), "R8 defaults forced", regs, model_flat());
        rail_on = 1'b1;
        wait_mode = 1'b0;
        if_enable = 1'b1;
        repeat (4) @(negedge clk);

        // Random write/read traffic (R2, R3, R5)
        for (int t = 0; t < 14; t++) begin
            int p;
            int n;
            addr_sel = 1'($urandom);
            p = int'($urandom % 10);
            n = 1 + int'($urandom % 3);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(addr_sel ? dev1 : dev0, 8'(p), n);
            for (int i = 0; i < n; i++) if (p + i < 8) model[p + i] = wbuf[i];
            check(regs === model_flat(), "R2 random write", regs, model_flat());
            p = int'($urandom % 10);
            n = 1 + int'($urandom % 3);
            do_read(addr_sel ? dev1 : dev0, 8'(p), n);
            verify_read(p, n, "R3 random read");
        end

        check(drive_viol == 0, "R9 drive changes only with SCL low", 64'(drive_viol), 64'd0);
        if (seed == 0) $display("seed %0d", seed);
        finish_run();
    end
endmodule